// File: doc/BRIEF.md
# Modular Double-to-Int32 Converter

This block turns a 64-bit IEEE double-precision operand into a signed 32-bit integer using wrap-around arithmetic. It does not clamp at the int32 limits. The operand is always truncated toward zero into an integer of unlimited width. The low 32 bits of that integer are kept and then sign-extended to a 64-bit general-purpose result. Code that stores every number as a double but needs 32-bit integer arithmetic can use it for fast conversion.

Alongside the result, the block reports two flags:
- An invalid flag, set when the true truncated value does not fit in a signed 32-bit integer, or when the operand is a NaN or an infinity.
- An inexact flag, set when a representable result dropped a fractional part.

A valid strobe travels with the data. The parameter `PIPE` selects either a purely combinational path (0) or one register stage (1, the default).

Top module: `dmod_cvt`

## Requirements
- R1: A finite operand whose truncated value lies in [-2^31, 2^31-1] yields that value; for example 5.0 gives 5 and 2147483647.0 gives 0x000000007FFFFFFF.
- R2: Rounding is always toward zero: -2.75 gives -2 (0xFFFFFFFFFFFFFFFE) and 2.75 gives 2.
- R3: For a negative operand, the full truncated magnitude is negated in two's complement before the low 32 bits are taken; -2^31 gives 0xFFFFFFFF80000000 with no invalid flag.
- R4: When the truncated magnitude needs more than 32 bits, only its low 32 bits are kept (wrap-around); for example 2^32+5 gives 5 and 2^31 gives 0xFFFFFFFF80000000.
- R5: When the unbiased exponent is 84 or more, and the operand is neither NaN nor infinity, the result is 0 and invalid is set.
- R6: An operand with the exponent field all ones (NaN or infinity, either sign) gives result 0, invalid set and inexact clear.
- R7: An operand with magnitude below 1.0 gives result 0 and never sets invalid. Inexact is set unless the operand is +0 or -0; this includes subnormals.
- R8: Invalid is set exactly when the truncated value lies outside [-2^31, 2^31-1], or under R6. Invalid and inexact are never set together.
- R9: Inexact is set when a fractional part was discarded and invalid is clear.
- R10: Bits 63..32 of the result always equal bit 31.
- R11: With PIPE=1, each accepted operand produces out_valid and its result exactly one cycle later. With PIPE=0, the output follows the input in the same cycle. out_valid is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result strobe |
| out_res | output | 64 | Sign-extended wrapped integer |
| out_invalid | output | 1 | Value out of int32 range, NaN or infinity |
| out_inexact | output | 1 | Fraction discarded on a representable result |

## Verification
The bound checker checks several properties on every cycle:
- The result always carries correct sign extension.
- The two flags are never raised together.
- The strobe and the data keep their fixed latency.
- Operands classified as special, huge or tiny produce a zero result with the correct flags.

Correct wrapped values need the bench's scoreboard. This covers the negation of the full magnitude, the boundary at -2^31 against +2^31, and the alignment of significand bits at each exponent. The bench predicts each result from the operand with an independent reference model and from directed literal values, including exponents near 52, 83 and 84.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  typedef enum logic [1:0] {
    CL_TINY = 2'd0,
    CL_NORM = 2'd1,
    CL_HUGE = 2'd2,
    CL_SPEC = 2'd3
  } cls_e;
endpackage

// File: rtl/dmod_unpack.sv
module dmod_unpack
  import dmod_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int OP_W   = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SH_MAX = INT_W + FRAC_W,
  localparam int SH_W   = $clog2(SH_MAX)
) (
  input  logic [OP_W-1:0]  op,
  output logic             sign,
  output cls_e             cls,
  output logic [SIG_W-1:0] sig,
  output logic [SH_W-1:0]  shamt,
  output logic             nonzero
);
  localparam logic [EXP_W-1:0] BIAS   = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] SH_LIM = EXP_W'(SH_MAX);

  logic [EXP_W-1:0] expf;
  logic [EXP_W-1:0] ue;

  assign sign    = op[OP_W-1];
  assign expf    = op[FRAC_W +: EXP_W];
  assign sig     = {1'b1, op[FRAC_W-1:0]};
  assign nonzero = |op[OP_W-2:0];
  assign ue      = expf - BIAS;

  always_comb begin
    cls   = CL_NORM;
    shamt = '0;
    if (&expf) begin
      cls = CL_SPEC;
    end else if (expf < BIAS) begin
      cls = CL_TINY;
    end else if (ue >= SH_LIM) begin
      cls = CL_HUGE;
    end else begin
      shamt = ue[SH_W-1:0];
    end
  end
endmodule

// File: rtl/dmod_align.sv
module dmod_align #(
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SH_MAX = INT_W + FRAC_W,
  localparam int SH_W   = $clog2(SH_MAX),
  localparam int WIDE_W = SIG_W + SH_MAX - 1,
  localparam int HI_W   = WIDE_W - FRAC_W - INT_W
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  shamt,
  input  logic             sign,
  output logic [INT_W-1:0] low,
  output logic             frac_nz,
  output logic             fits
);
  logic [WIDE_W-1:0] wide;
  logic [HI_W-1:0]   hi;

  function automatic logic f_fits(input logic neg, input logic hi_nz,
                                  input logic [INT_W-1:0] v);
    if (hi_nz) return 1'b0;
    if (!v[INT_W-1]) return 1'b1;
    return neg && (v[INT_W-2:0] == '0);
  endfunction

  assign wide    = {{(WIDE_W-SIG_W){1'b0}}, sig} << shamt;
  assign low     = wide[FRAC_W +: INT_W];
  assign hi      = wide[WIDE_W-1 -: HI_W];
  assign frac_nz = |wide[FRAC_W-1:0];
  assign fits    = f_fits(sign, |hi, low);
endmodule

// File: rtl/dmod_pack.sv
module dmod_pack
  import dmod_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int OUT_W = 64
) (
  input  cls_e             cls,
  input  logic             sign,
  input  logic             nonzero,
  input  logic [INT_W-1:0] low,
  input  logic             frac_nz,
  input  logic             fits,
  output logic [OUT_W-1:0] res,
  output logic             inv,
  output logic             inex
);
  function automatic logic [OUT_W-1:0] f_wrap(input logic neg,
                                              input logic [INT_W-1:0] v);
    logic [INT_W-1:0] w;
    w = neg ? (~v + 1'b1) : v;
    return {{(OUT_W-INT_W){w[INT_W-1]}}, w};
  endfunction

  always_comb begin
    res  = '0;
    inv  = 1'b0;
    inex = 1'b0;
    unique case (cls)
      CL_SPEC: inv = 1'b1;
      CL_HUGE: inv = 1'b1;
      CL_TINY: inex = nonzero;
      default: begin
        res  = f_wrap(sign, low);
        inv  = !fits;
        inex = fits && frac_nz;
      end
    endcase
  end
endmodule

// File: rtl/dmod_cvt.sv
module dmod_cvt
  import dmod_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  parameter int OUT_W  = 64,
  parameter int PIPE   = 1,
  localparam int OP_W   = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SH_W   = $clog2(INT_W + FRAC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_res,
  output logic             out_invalid,
  output logic             out_inexact
);
  logic             c_sign;
  cls_e             c_cls;
  logic [SIG_W-1:0] c_sig;
  logic [SH_W-1:0]  c_shamt;
  logic             c_nonzero;
  logic [INT_W-1:0] c_low;
  logic             c_frac_nz;
  logic             c_fits;
  logic [OUT_W-1:0] c_res;
  logic             c_inv;
  logic             c_inex;

  dmod_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
    .op(in_op), .sign(c_sign), .cls(c_cls), .sig(c_sig),
    .shamt(c_shamt), .nonzero(c_nonzero)
  );

  dmod_align #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .sig(c_sig), .shamt(c_shamt), .sign(c_sign),
    .low(c_low), .frac_nz(c_frac_nz), .fits(c_fits)
  );

  dmod_pack #(.INT_W(INT_W), .OUT_W(OUT_W)) u_pack (
    .cls(c_cls), .sign(c_sign), .nonzero(c_nonzero), .low(c_low),
    .frac_nz(c_frac_nz), .fits(c_fits),
    .res(c_res), .inv(c_inv), .inex(c_inex)
  );

  generate
    if (PIPE == 0) begin : g_comb
      assign out_valid   = in_valid;
      assign out_res     = c_res;
      assign out_invalid = c_inv;
      assign out_inexact = c_inex;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_res     <= '0;
          out_invalid <= 1'b0;
          out_inexact <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_res     <= c_res;
            out_invalid <= c_inv;
            out_inexact <= c_inex;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dmod_cvt_chk.sv
module dmod_cvt_chk
  import dmod_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int OUT_W = 64,
  parameter int PIPE  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_res,
  input logic             out_invalid,
  input logic             out_inexact,
  input cls_e             c_cls,
  input logic [OUT_W-1:0] c_res,
  input logic             c_inv,
  input logic             c_inex
);
  p_special_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_cls == CL_SPEC) |-> (c_res == '0 && c_inv && !c_inex));

  p_huge_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_cls == CL_HUGE) |-> (c_res == '0 && c_inv));

  p_tiny_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_cls == CL_TINY) |-> (c_res == '0 && !c_inv));

  p_sign_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_res[OUT_W-1:INT_W] == {(OUT_W-INT_W){out_res[INT_W-1]}}));

  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  generate
    if (PIPE != 0) begin : g_lat
      p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_idle_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_data_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_res == $past(c_res) && out_invalid == $past(c_inv)
                      && out_inexact == $past(c_inex)));
    end else begin : g_now
      p_valid_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
    end
  endgenerate
endmodule

bind dmod_cvt dmod_cvt_chk #(.INT_W(INT_W), .OUT_W(OUT_W), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_res(out_res), .out_invalid(out_invalid), .out_inexact(out_inexact),
  .c_cls(c_cls), .c_res(c_res), .c_inv(c_inv), .c_inex(c_inex)
);

// File: tb/dmod_cvt_tb_top.sv
module dmod_cvt_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        inex;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        out_valid;
  logic [63:0] out_res;
  logic        out_invalid;
  logic        out_inexact;

  int   n_total = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmod_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_res(out_res),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  function automatic exp_t ref_model(input logic [63:0] x, input string tag);
    exp_t        e;
    int          ue;
    logic [127:0] w;
    logic [63:0] mag;
    logic [52:0] m;
    logic [31:0] lo;
    logic        frac;
    logic        fits;
    e.tag = tag; e.res = '0; e.inv = 1'b0; e.inex = 1'b0;
    m = {1'b1, x[51:0]};
    if (x[62:52] == 11'h7FF) begin
      e.inv = 1'b1;
    end else if (x[62:52] < 11'd1023) begin
      e.inex = (x[62:0] != 63'd0);
    end else begin
      ue = int'(x[62:52]) - 1023;
      frac = 1'b0;
      if (ue >= 84) begin
        lo = '0; fits = 1'b0;
      end else if (ue > 52) begin
        w = {75'd0, m} << (ue - 52);
        lo = w[31:0]; fits = 1'b0;
      end else begin
        mag = {11'd0, m} >> (52 - ue);
        frac = ((m & ((53'd1 << (52 - ue)) - 53'd1)) != 53'd0);
        fits = x[63] ? (mag <= 64'h8000_0000) : (mag <= 64'h7FFF_FFFF);
        lo = mag[31:0];
      end
      if (x[63]) lo = -lo;
      if (ue < 84) e.res = {{32{lo[31]}}, lo};
      e.inv = !fits;
      e.inex = fits && frac;
    end
    return e;
  endfunction

  task automatic send_lit(input logic [63:0] x, input logic [63:0] r,
                          input logic iv, input logic ix, input string tag);
    exp_t e;
    e.res = r; e.inv = iv; e.inex = ix; e.tag = tag;
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = x;
    sb.push_back(e);
  endtask

  task automatic send_ref(input logic [63:0] x, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = x;
    sb.push_back(ref_model(x, tag));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_total++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected out_valid act=1 exp=0");
      end else begin
        e = sb.pop_front();
        if (out_res !== e.res || out_invalid !== e.inv || out_inexact !== e.inex) begin
          n_bad++;
          $display("FAIL %s res act=%h exp=%h inv act=%b exp=%b inex act=%b exp=%b",
                   e.tag, out_res, e.res, out_invalid, e.inv, out_inexact, e.inex);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_total++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset out_valid act=%b exp=0", out_valid);
    end
    rst_n = 1'b1;
    // R1 plain values
    send_lit(64'h3FF0_0000_0000_0000, 64'd1, 0, 0, "R1");
    send_lit(64'h4014_0000_0000_0000, 64'd5, 0, 0, "R1");
    send_lit(64'h41DF_FFFF_FFC0_0000, 64'h0000_0000_7FFF_FFFF, 0, 0, "R1");
    // R2 / R9 toward zero with inexact
    send_lit(64'hC006_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R2");
    send_lit(64'h4006_0000_0000_0000, 64'd2, 0, 1, "R9");
    // R3 negative boundary
    send_lit(64'hC1E0_0000_0000_0000, 64'hFFFF_FFFF_8000_0000, 0, 0, "R3");
    send_lit(64'hBFF0_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R3");
    // R4 / R8 wrap-around
    send_lit(64'h41E0_0000_0000_0000, 64'hFFFF_FFFF_8000_0000, 1, 0, "R4");
    send_lit(64'h41F0_0000_0050_0000, 64'd5, 1, 0, "R4");
    send_lit(64'h4520_0000_0000_0001, 64'hFFFF_FFFF_8000_0000, 1, 0, "R4");
    send_lit(64'hC520_0000_0000_0001, 64'hFFFF_FFFF_8000_0000, 1, 0, "R8");
    // R5 exponent 84 and above
    send_lit(64'h4530_0000_0000_0000, 64'd0, 1, 0, "R5");
    send_lit(64'hC53F_FFFF_FFFF_FFFF, 64'd0, 1, 0, "R5");
    // R6 specials
    send_lit(64'h7FF0_0000_0000_0000, 64'd0, 1, 0, "R6");
    send_lit(64'hFFF0_0000_0000_0000, 64'd0, 1, 0, "R6");
    send_lit(64'h7FF8_0000_0000_0000, 64'd0, 1, 0, "R6");
    // R7 below one
    send_lit(64'h3FE0_0000_0000_0000, 64'd0, 0, 1, "R7");
    send_lit(64'h0000_0000_0000_0001, 64'd0, 0, 1, "R7");
    send_lit(64'h0000_0000_0000_0000, 64'd0, 0, 0, "R7");
    send_lit(64'h8000_0000_0000_0000, 64'd0, 0, 0, "R7");
    // idle gap, then R10 random exponents near the interesting range
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x;
      lf ^= lf << 13; lf ^= lf >> 7; lf ^= lf << 17;
      x = lf;
      x[62:52] = 11'(1000 + (lf[31:16] % 16'd130));
      send_ref(x, "R10");
      if (i % 7 == 3) begin
        @(posedge clk); #1; in_valid = 1'b0;
      end
    end
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_total++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending results act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule